// File: doc/BRIEF.md
# Event-Code Matched Delayed Trigger Generator

This block watches a stream of 8-bit event codes, one per event-clock cycle, and drives a bank of hardware trigger lines. Each trigger channel has its own enable, its own programmed code, a delay and a pulse width. When the incoming code equals a channel's programmed code, that channel counts out its delay and then holds its trigger line high for the programmed number of cycles.

Channels are set up through a single-cycle register write port that addresses one channel and one field at a time. A channel refuses changes while it is counting, except for a request to disable it, which aborts any delay or pulse at once. A hit that arrives while a channel is already busy is dropped, and the channel raises a sticky flag so the overlap can be seen.

Top module: `evt_trig_top`

## Requirements
- R1: After synchronous reset every channel is disabled, with a zero code, zero delay and zero width, all trigger outputs low and all overlap flags clear.
- R2: A write with `cfg_we` high updates channel `cfg_ch`. Field select 0 is control (bit 0 enable, bits 15:8 event code), select 1 is delay, select 2 is width, and select 3 changes nothing.
- R3: A channel registers a hit only when it is enabled, its programmed code is non-zero, and the input code equals it. Code 0 never causes a hit.
- R4: If a hit is sampled at clock edge N with delay D and width W, the trigger output is high after edges N+D through N+D+W-1, which is exactly W cycles, and low after edge N+D+W.
- R5: A delay of 0 makes the output go high directly after the edge that samples the hit.
- R6: A width of 0 suppresses the pulse. The hit neither drives the output nor makes the channel busy.
- R7: A hit that arrives while a channel is delaying or pulsing is ignored and sets that channel's overlap flag. The flag stays set until a write to that channel takes effect.
- R8: A control write with enable 0 takes effect at once, even on a busy channel. The output is low after that edge and no pending pulse follows.
- R9: Any other write to a channel that is delaying or pulsing is ignored. This includes enable-1 control writes and delay or width writes.
- R10: Channels run independently, and one event code can fire several channels, each with its own timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_code | input | 8 | Incoming event code, one per cycle; 0 means no event |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | Field select: 0 control, 1 delay, 2 width, 3 none |
| cfg_data | input | 32 | Write data |
| trig_out | output | 8 | Trigger output per channel |
| overlap_flag | output | 8 | Sticky overlap flag per channel |

## Verification
The bench times every pulse edge against the cycle its hit was sampled. An off-by-one in the delay or width counter therefore shows up as a shifted or shortened pulse, and a design that treated delay 0 like delay 1 would rise one cycle late. It sends a second hit during the delay phase and writes width and code while a channel is busy. A design that restarted on the second hit, or took the busy write, would produce a pulse at the wrong time or of the wrong length, or no overlap flag. It also aborts one channel during its delay and another mid-pulse. It fires a code-0 channel, a disabled channel and a width-0 channel, where any pulse counts as unexpected, and a width-0 hit that made the channel busy would set the overlap flag.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;

    parameter int CODE_W        = 8;
    parameter int CNT_W         = 32;
    parameter int SEL_W         = 2;
    parameter int CTRL_CODE_LSB = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } chan_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DELAY = 2'd1,
        SEL_WIDTH = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  dly;
        logic [CNT_W-1:0]  wid;
    } chan_cfg_t;

    function automatic logic code_hit(input logic en,
                                      input logic [CODE_W-1:0] prog,
                                      input logic [CODE_W-1:0] incoming);
        return en && (prog != '0) && (incoming == prog);
    endfunction

endpackage

// File: rtl/evt_trig_wdec.sv
module evt_trig_wdec #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input  logic              we,
    input  logic [CH_W-1:0]   ch,
    output logic [NUM_CH-1:0] strobe
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_dec
            assign strobe[gi] = we && (ch == CH_W'(gi));
        end
    endgenerate

endmodule

// File: rtl/evt_trig_chan.sv
module evt_trig_chan
    import evt_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              trig,
    output logic              overlap
);

    chan_cfg_t        cfg;
    chan_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             ovl;
    logic             hit;
    logic             wr_disable;
    logic             busy;

    assign hit        = code_hit(cfg.en, cfg.code, evt_code);
    assign busy       = (state != ST_IDLE);
    assign wr_disable = wr_en && (cfg_sel_e'(wr_sel) == SEL_CTRL) && !wr_data[0];
    assign trig       = (state == ST_PULSE);
    assign overlap    = ovl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            state <= ST_IDLE;
            cnt   <= '0;
            ovl   <= 1'b0;
        end else if (busy && wr_disable) begin
            cfg.en <= 1'b0;
            state  <= ST_IDLE;
            cnt    <= '0;
            ovl    <= 1'b0;
        end else if (!busy && wr_en) begin
            ovl <= 1'b0;
            case (cfg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    cfg.en   <= wr_data[0];
                    cfg.code <= wr_data[CTRL_CODE_LSB +: CODE_W];
                end
                SEL_DELAY: cfg.dly <= wr_data;
                SEL_WIDTH: cfg.wid <= wr_data;
                default: ;
            endcase
        end else begin
            case (state)
                ST_IDLE: begin
                    if (hit && (cfg.wid != '0)) begin
                        if (cfg.dly == '0) begin
                            state <= ST_PULSE;
                            cnt   <= cfg.wid;
                        end else begin
                            state <= ST_DELAY;
                            cnt   <= cfg.dly;
                        end
                    end
                end
                ST_DELAY: begin
                    if (hit) ovl <= 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_PULSE;
                        cnt   <= cfg.wid;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (hit) ovl <= 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a disabled channel never drives its trigger
    assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !trig);

    // R9: a non-disable write to a busy channel leaves its setup untouched
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !wr_disable) |=>
            ($stable(cfg.code) && $stable(cfg.dly) && $stable(cfg.wid) && $stable(cfg.en)));

    // R7: a hit during a busy phase raises the sticky flag
    assert_overlap_set_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && busy && !wr_en) |=> overlap);

    // R5: zero delay pulses right after the hit edge
    assert_zero_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en && hit && (cfg.dly == '0) && (cfg.wid != '0)) |=> trig);

    // R6: zero width produces no pulse and no busy phase
    assert_zero_width_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en && hit && (cfg.wid == '0)) |=> (!trig && (state == ST_IDLE)));

endmodule

// File: rtl/evt_trig_top.sv
module evt_trig_top
    import evt_trig_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CNT_W-1:0]  cfg_data,
    output logic [NUM_CH-1:0] trig_out,
    output logic [NUM_CH-1:0] overlap_flag
);

    logic [NUM_CH-1:0] wr_strobe;

    evt_trig_wdec #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_wdec (
        .we     (cfg_we),
        .ch     (cfg_ch),
        .strobe (wr_strobe)
    );

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
            evt_trig_chan u_chan (
                .clk      (clk),
                .rst      (rst),
                .evt_code (evt_code),
                .wr_en    (wr_strobe[gc]),
                .wr_sel   (cfg_sel),
                .wr_data  (cfg_data),
                .trig     (trig_out[gc]),
                .overlap  (overlap_flag[gc])
            );
        end
    endgenerate

    // R2: a write reaches at most one channel
    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_strobe));

    // R1: outputs are quiet on the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> ((trig_out == '0) && (overlap_flag == '0)));

endmodule

// File: tb/evt_trig_top_bench.sv
module evt_trig_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt = 8'h00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = 3'd0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = 32'd0;
    logic [NCH-1:0] trig_out;
    logic [NCH-1:0] overlap_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int ch;
        int rise;
        int width;
    } exp_t;

    exp_t sbq[$];
    logic [NCH-1:0] prev_trig = '0;
    int start_cyc[NCH];

    evt_trig_top u_evt_trig_top (
        .clk          (clk),
        .rst          (rst),
        .evt_code     (evt),
        .cfg_we       (cfg_we),
        .cfg_ch       (cfg_ch),
        .cfg_sel      (cfg_sel),
        .cfg_data     (cfg_data),
        .trig_out     (trig_out),
        .overlap_flag (overlap_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: measure each pulse and pop the matching expectation
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                if (trig_out[c] && !prev_trig[c]) start_cyc[c] = cyc;
                if (!trig_out[c] && prev_trig[c]) begin
                    int idx;
                    idx = -1;
                    for (int i = 0; i < sbq.size(); i++)
                        if (idx < 0 && sbq[i].ch == c) idx = i;
                    checks++;
                    if (idx < 0) begin
                        errors++;
                        $display("FAIL R3 unexpected pulse ch%0d actual=rise%0d expected=none", c, start_cyc[c]);
                    end else begin
                        if (sbq[idx].rise != start_cyc[c] || sbq[idx].width != cyc - start_cyc[c]) begin
                            errors++;
                            $display("FAIL R4 ch%0d actual=rise%0d/w%0d expected=rise%0d/w%0d",
                                     c, start_cyc[c], cyc - start_cyc[c], sbq[idx].rise, sbq[idx].width);
                        end
                        sbq.delete(idx);
                    end
                end
            end
            prev_trig = trig_out;
        end
    end

    task automatic wr(input int ch, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_data = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input int code, input int d, input int w);
        wr(ch, 1, d);
        wr(ch, 2, w);
        wr(ch, 0, (code << 8) | 1);
    endtask

    task automatic fire(input int code, output int hit);
        @(negedge clk);
        evt = 8'(code);
        @(negedge clk);
        hit = cyc;
        evt = 8'h00;
    endtask

    task automatic expect_pulse(input int ch, input int hit, input int d, input int w);
        exp_t e;
        e.ch = ch; e.rise = hit + d; e.width = w;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int h;
        int h2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(trig_out == '0, "R1 trig after reset", int'(trig_out), 0);
        check(overlap_flag == '0, "R1 flags after reset", int'(overlap_flag), 0);
        fire(8'h01, h);   // R1: all channels disabled, no pulse expected
        idle(5);

        // R2, R4: basic delayed pulse
        setup(0, 8'h21, 5, 4);
        fire(8'h21, h); expect_pulse(0, h, 5, 4);
        idle(15);

        // R5: zero delay
        setup(1, 8'h22, 0, 2);
        fire(8'h22, h); expect_pulse(1, h, 0, 2);
        idle(6);

        // R10: one code fires two channels
        setup(2, 8'h30, 3, 2);
        setup(3, 8'h30, 7, 5);
        fire(8'h30, h); expect_pulse(2, h, 3, 2); expect_pulse(3, h, 7, 5);
        idle(16);

        // R6: zero width, no pulse and no busy phase
        setup(4, 8'h40, 2, 0);
        fire(8'h40, h); idle(1);
        fire(8'h40, h); idle(5);
        check(overlap_flag[4] == 1'b0, "R6 width0 overlap", int'(overlap_flag[4]), 0);

        // R7: overlap flag, sticky until accepted write
        wr(0, 1, 10); wr(0, 2, 3);
        fire(8'h21, h); expect_pulse(0, h, 10, 3);
        fire(8'h21, h2);
        idle(1);
        check(overlap_flag[0] == 1'b1, "R7 overlap set", int'(overlap_flag[0]), 1);
        idle(16);
        check(overlap_flag[0] == 1'b1, "R7 overlap sticky", int'(overlap_flag[0]), 1);
        wr(0, 1, 10);
        idle(1);
        check(overlap_flag[0] == 1'b0, "R7 overlap cleared", int'(overlap_flag[0]), 0);

        // R9: busy writes ignored (width and code)
        fire(8'h21, h); expect_pulse(0, h, 10, 3);
        wr(0, 2, 20);
        wr(0, 0, (8'h55 << 8) | 1);
        idle(16);
        fire(8'h21, h); expect_pulse(0, h, 10, 3);
        idle(16);

        // R8: abort during delay
        fire(8'h21, h);
        idle(1);
        wr(0, 0, 0);
        check(trig_out[0] == 1'b0, "R8 abort in delay", int'(trig_out[0]), 0);
        idle(16);
        wr(0, 0, (8'h21 << 8) | 1);

        // R8: abort mid-pulse, pulse truncated at the write edge
        setup(5, 8'h50, 2, 30);
        fire(8'h50, h);
        expect_pulse(5, h, 2, 5);
        idle(5);
        wr(5, 0, 0);
        check(trig_out[5] == 1'b0, "R8 abort in pulse", int'(trig_out[5]), 0);
        idle(40);

        // R3: code 0 channel and disabled channel never fire
        wr(6, 1, 1); wr(6, 2, 1); wr(6, 0, 1);
        fire(8'h00, h); idle(8);
        wr(7, 1, 1); wr(7, 2, 1); wr(7, 0, 8'h70 << 8);
        fire(8'h70, h); idle(8);
        // R2: select 3 writes change nothing
        wr(7, 3, 32'h0000FFFF);
        wr(7, 0, (8'h70 << 8) | 1);
        fire(8'h70, h); expect_pulse(7, h, 1, 1);
        idle(10);

        check(sbq.size() == 0, "R4 missing pulses", sbq.size(), 0);
        summary();
    end

endmodule